// File: doc/BRIEF.md
# Two-Wire Bus Repeater with Data Direction Lock

The block joins two segments of an open-drain two-wire bus, a master segment and a slave segment, inside a synchronous design. For each wire on each segment it takes a sampled line level and returns a pull-low request. It never drives a line high. The data wire is repeated in both directions. Whichever segment is first seen low owns the wire, and the block pulls the other segment low. The other segment's own level is disregarded until the owner lets go. When the owner releases while a device on the far segment still holds its side low, ownership passes to that segment and the block now pulls the former owner low.

The clock wire is repeated one way only, so a device that stretches the clock on the receiving segment is not seen on the driving segment. A direction input picks the way. An enable input connects or isolates the two segments. A change on the enable input is applied only after all four lines have been high for a set number of cycles, so a transaction in progress is never cut short.

Top module: `twbus_repeater`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four pull outputs are low, and the link starts in the isolated state.
- R2: With the link connected and the data wire idle, a low on one data side makes the block pull the opposite data side exactly three clock edges after the low is first presented, and the low side itself is not pulled.
- R3: While one side owns the data wire, a low on the other side does not cause the owner's side to be pulled.
- R4: When the owner's line returns high while the other side is still held low by an outside device, the other side becomes owner after a settle window of at least sync-depth plus one cycles. There is always at least one cycle between the two data pulls.
- R5: If both data sides are first seen low in the same cycle, the master side wins and only the slave side is pulled.
- R6: After a handover, the new owner keeps ownership for HOLD_CYCLES cycles even if its line rises sooner, so the former owner stays pulled for that time.
- R7: The two data pull outputs are never high in the same cycle.
- R8: With the direction input low, the slave-side clock pull follows the inverted master-side clock level two edges later. The master-side clock pull stays low even when the slave side is held low.
- R9: With the direction input high, the master-side clock pull follows the inverted slave-side clock level two edges later, and the slave-side clock pull stays low.
- R10: The connected state changes only after all four lines have been high for IDLE_CYCLES consecutive cycles. While the link is isolated, no pull output is asserted.
- R11: When an owner releases and the other side is high, the data wire returns to idle with neither side pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Requested link state, 1 = connect segments |
| scl_dir | input | 1 | Clock direction: 0 = master to slave, 1 = slave to master |
| sda_m_in | input | 1 | Master-side data line level |
| sda_s_in | input | 1 | Slave-side data line level |
| scl_m_in | input | 1 | Master-side clock line level |
| scl_s_in | input | 1 | Slave-side clock line level |
| sda_m_pull | output | 1 | Pull master-side data line low |
| sda_s_pull | output | 1 | Pull slave-side data line low |
| scl_m_pull | output | 1 | Pull master-side clock line low |
| scl_s_pull | output | 1 | Pull slave-side clock line low |

## Verification
The hardest case to reach is the handover window. The owner must release at the moment an outside device on the other segment is still holding its side low, and that device must then let go within the hold period. Only that sequence shows the difference between a correct hold and an early reversal. The bench models each wire as the AND of an outside driver and the inverted pull, so the block's own pull feeds back into its input as it would on a real bus. Directed steps poll for the exact edge on which the handover pull appears, and release the outside device on that same cycle. Seeded random traffic on all four wires then checks data pull exclusivity and the two-cycle clock path in both directions.

// File: rtl/twbr_pkg.sv
package twbr_pkg;

    typedef enum logic [1:0] {
        OWN_IDLE   = 2'd0,
        OWN_M      = 2'd1,
        OWN_S      = 2'd2,
        OWN_SETTLE = 2'd3
    } own_state_e;

    typedef enum logic {
        SIDE_M = 1'b0,
        SIDE_S = 1'b1
    } side_e;

    typedef struct packed {
        logic sda_m;
        logic sda_s;
        logic scl_m;
        logic scl_s;
    } lines_t;

    localparam int LINE_COUNT = $bits(lines_t);

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_bits(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/twbr_sync.sv
module twbr_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= '1;
                end else if (g == 0) begin
                    stage_q[g] <= d;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/twbr_link_gate.sv
module twbr_link_gate
    import twbr_pkg::*;
#(
    parameter int IDLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic idle,
    output logic on
);
    localparam int CW = cnt_bits(IDLE_CYCLES);
    localparam logic [CW-1:0] CNT_MAX = CW'(IDLE_CYCLES);

    logic [CW-1:0] idle_cnt;
    logic          on_q;
    logic          quiet;

    assign quiet = idle && (idle_cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            on_q     <= 1'b0;
        end else begin
            if (!idle) begin
                idle_cnt <= '0;
            end else if (idle_cnt != CNT_MAX) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
            if (quiet && (req != on_q)) begin
                on_q <= req;
            end
        end
    end

    assign on = on_q;
endmodule

// File: rtl/twbr_data_lock.sv
module twbr_data_lock
    import twbr_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int GUARD_CYCLES = 4,
    parameter int HOLD_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic m_low,
    input  logic s_low,
    output logic pull_m,
    output logic pull_s
);
    localparam int GUARD_EFF = max_int(GUARD_CYCLES, SYNC_STAGES + 1);
    localparam int GW        = cnt_bits(GUARD_EFF);
    localparam int HW        = cnt_bits(HOLD_CYCLES);
    localparam logic [GW-1:0] GUARD_LOAD = GW'(GUARD_EFF - 1);
    localparam logic [HW-1:0] HOLD_LOAD  = HW'(HOLD_CYCLES);

    own_state_e    state_q, state_d;
    side_e         prev_q, prev_d;
    logic [GW-1:0] guard_q, guard_d;
    logic [HW-1:0] hold_q, hold_d;
    logic          former_low, other_low;

    assign former_low = (prev_q == SIDE_M) ? m_low : s_low;
    assign other_low  = (prev_q == SIDE_M) ? s_low : m_low;

    always_comb begin
        state_d = state_q;
        prev_d  = prev_q;
        guard_d = guard_q;
        hold_d  = hold_q;
        unique case (state_q)
            OWN_IDLE: begin
                hold_d = '0;
                if (m_low) begin
                    state_d = OWN_M;
                end else if (s_low) begin
                    state_d = OWN_S;
                end
            end
            OWN_M, OWN_S: begin
                if (hold_q != '0) begin
                    hold_d = hold_q - 1'b1;
                end else if ((state_q == OWN_M) ? !m_low : !s_low) begin
                    state_d = OWN_SETTLE;
                    prev_d  = (state_q == OWN_M) ? SIDE_M : SIDE_S;
                    guard_d = GUARD_LOAD;
                end
            end
            OWN_SETTLE: begin
                if (former_low) begin
                    state_d = (prev_q == SIDE_M) ? OWN_M : OWN_S;
                    hold_d  = '0;
                end else if (guard_q == '0) begin
                    if (other_low) begin
                        state_d = (prev_q == SIDE_M) ? OWN_S : OWN_M;
                        hold_d  = HOLD_LOAD;
                    end else begin
                        state_d = OWN_IDLE;
                    end
                end else begin
                    guard_d = guard_q - 1'b1;
                end
            end
            default: state_d = OWN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state_q <= OWN_IDLE;
            prev_q  <= SIDE_M;
            guard_q <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= prev_d;
            guard_q <= guard_d;
            hold_q  <= hold_d;
        end
    end

    assign pull_s = (state_q == OWN_M);
    assign pull_m = (state_q == OWN_S);
endmodule

// File: rtl/twbus_repeater.sv
module twbus_repeater
    import twbr_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int IDLE_CYCLES  = 8,
    parameter int GUARD_CYCLES = 4,
    parameter int HOLD_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic link_en,
    input  logic scl_dir,
    input  logic sda_m_in,
    input  logic sda_s_in,
    input  logic scl_m_in,
    input  logic scl_s_in,
    output logic sda_m_pull,
    output logic sda_s_pull,
    output logic scl_m_pull,
    output logic scl_s_pull
);
    lines_t raw_lines;
    lines_t sync_lines;
    logic   en_on;
    logic   idle_now;
    logic   lock_pull_m, lock_pull_s;

    assign raw_lines = '{sda_m: sda_m_in, sda_s: sda_s_in,
                         scl_m: scl_m_in, scl_s: scl_s_in};

    twbr_sync #(.WIDTH(LINE_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    assign idle_now = &sync_lines;

    twbr_link_gate #(.IDLE_CYCLES(IDLE_CYCLES)) u_gate (
        .clk  (clk),
        .rst  (rst),
        .req  (link_en),
        .idle (idle_now),
        .on   (en_on)
    );

    twbr_data_lock #(
        .SYNC_STAGES  (SYNC_STAGES),
        .GUARD_CYCLES (GUARD_CYCLES),
        .HOLD_CYCLES  (HOLD_CYCLES)
    ) u_lock (
        .clk    (clk),
        .rst    (rst),
        .clear  (!en_on),
        .m_low  (!sync_lines.sda_m),
        .s_low  (!sync_lines.sda_s),
        .pull_m (lock_pull_m),
        .pull_s (lock_pull_s)
    );

    assign sda_m_pull = en_on && lock_pull_m;
    assign sda_s_pull = en_on && lock_pull_s;
    assign scl_s_pull = en_on && !scl_dir && !sync_lines.scl_m;
    assign scl_m_pull = en_on &&  scl_dir && !sync_lines.scl_s;
endmodule

// File: rtl/twbr_checker.sv
module twbr_checker (
    input logic clk,
    input logic rst,
    input logic scl_dir,
    input logic en_on,
    input logic idle_now,
    input logic sda_m_pull,
    input logic sda_s_pull,
    input logic scl_m_pull,
    input logic scl_s_pull
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !(sda_m_pull || sda_s_pull || scl_m_pull || scl_s_pull));

    assert_data_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(sda_m_pull && sda_s_pull));

    assert_gap_ms_R4: assert property (@(posedge clk) disable iff (rst)
        sda_s_pull |=> !sda_m_pull);

    assert_gap_sm_R4: assert property (@(posedge clk) disable iff (rst)
        sda_m_pull |=> !sda_s_pull);

    assert_clk_fwd_R8: assert property (@(posedge clk) disable iff (rst)
        !scl_dir |-> !scl_m_pull);

    assert_clk_rev_R9: assert property (@(posedge clk) disable iff (rst)
        scl_dir |-> !scl_s_pull);

    assert_en_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (en_on != $past(en_on)) |-> $past(idle_now));
endmodule

bind twbus_repeater twbr_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_dir    (scl_dir),
    .en_on      (en_on),
    .idle_now   (idle_now),
    .sda_m_pull (sda_m_pull),
    .sda_s_pull (sda_s_pull),
    .scl_m_pull (scl_m_pull),
    .scl_s_pull (scl_s_pull)
);

// File: tb/tb_twbus_repeater.sv
module tb_twbus_repeater;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_en = 1'b0;
    logic scl_dir = 1'b0;
    logic em_sda = 1'b1, es_sda = 1'b1, em_scl = 1'b1, es_scl = 1'b1;
    logic sda_m_pull, sda_s_pull, scl_m_pull, scl_s_pull;
    logic sda_m_line, sda_s_line, scl_m_line, scl_s_line;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_m_line = em_sda & ~sda_m_pull;
    assign sda_s_line = es_sda & ~sda_s_pull;
    assign scl_m_line = em_scl & ~scl_m_pull;
    assign scl_s_line = es_scl & ~scl_s_pull;

    twbus_repeater dut (
        .clk        (clk),
        .rst        (rst),
        .link_en    (link_en),
        .scl_dir    (scl_dir),
        .sda_m_in   (sda_m_line),
        .sda_s_in   (sda_s_line),
        .scl_m_in   (scl_m_line),
        .scl_s_in   (scl_s_line),
        .sda_m_pull (sda_m_pull),
        .sda_s_pull (sda_s_pull),
        .scl_m_pull (scl_m_pull),
        .scl_s_pull (scl_s_pull)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic clk_expect(input logic past_level);
        return ~past_level;
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic h1, h2, found;
        void'($urandom(32'h5eed_0042));
        step(3);
        chk("R1 sda_m", sda_m_pull, 1'b0);
        chk("R1 sda_s", sda_s_pull, 1'b0);
        chk("R1 scl_m", scl_m_pull, 1'b0);
        chk("R1 scl_s", scl_s_pull, 1'b0);
        rst = 1'b0;
        step(1);
        chk("R1 post", sda_s_pull | scl_s_pull, 1'b0);

        // R10: isolated before enable
        em_sda = 1'b0; step(6);
        chk("R10 isolated", sda_s_pull, 1'b0);
        em_sda = 1'b1;

        link_en = 1'b1; step(25);

        // R8: forward clock with two-edge latency
        em_scl = 1'b0; step(1);
        chk("R8 latency", scl_s_pull, 1'b0);
        step(1);
        chk("R8 forward", scl_s_pull, 1'b1);
        es_scl = 1'b0; step(4);
        chk("R8 no stretch back", scl_m_pull, 1'b0);
        em_scl = 1'b1; es_scl = 1'b1; step(4);
        chk("R8 release", scl_s_pull, 1'b0);

        // R9: reverse clock
        scl_dir = 1'b1;
        es_scl = 1'b0; step(2);
        chk("R9 reverse", scl_m_pull, 1'b1);
        chk("R9 other side", scl_s_pull, 1'b0);
        es_scl = 1'b1; step(4);
        scl_dir = 1'b0;

        // R2: master low takes ownership in three edges
        em_sda = 1'b0; step(2);
        chk("R2 latency", sda_s_pull, 1'b0);
        step(1);
        chk("R2 pull slave", sda_s_pull, 1'b1);
        chk("R2 owner free", sda_m_pull, 1'b0);

        // R3: slave low is locked out
        es_sda = 1'b0; step(6);
        chk("R3 lockout", sda_m_pull, 1'b0);

        // R4: handover to the slave side after master releases
        em_sda = 1'b1;
        found = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (sda_m_pull) begin
                found = 1'b1;
                break;
            end
        end
        chk("R4 handover", found, 1'b1);
        chk("R4 old pull off", sda_s_pull, 1'b0);
        // R6: slave device lets go at once; hold keeps ownership
        es_sda = 1'b1; step(4);
        chk("R6 hold", sda_m_pull, 1'b1);
        step(14);
        chk("R11 idle m", sda_m_pull, 1'b0);
        chk("R11 idle s", sda_s_pull, 1'b0);

        // R11: plain release with no outside hold
        em_sda = 1'b0; step(5);
        em_sda = 1'b1; step(12);
        chk("R11 release", sda_s_pull | sda_m_pull, 1'b0);

        // R5: same-cycle lows, master wins
        em_sda = 1'b0; es_sda = 1'b0; step(4);
        chk("R5 slave pulled", sda_s_pull, 1'b1);
        chk("R5 master free", sda_m_pull, 1'b0);
        em_sda = 1'b1; es_sda = 1'b1; step(25);

        // R7/R8/R9 random traffic
        for (int d = 0; d < 2; d++) begin
            scl_dir = d[0];
            h1 = 1'b1; h2 = 1'b1;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (i >= 3) begin
                    chk("R7 exclusive", sda_m_pull & sda_s_pull, 1'b0);
                    if (d == 0) begin
                        chk("R8 random", scl_s_pull, clk_expect(h2));
                        chk("R8 one way", scl_m_pull, 1'b0);
                    end else begin
                        chk("R9 random", scl_m_pull, clk_expect(h2));
                        chk("R9 one way", scl_s_pull, 1'b0);
                    end
                end
                em_sda = ($urandom % 3) != 0;
                es_sda = ($urandom % 3) != 0;
                em_scl = $urandom % 2;
                es_scl = $urandom % 2;
                h2 = h1;
                h1 = (d == 0) ? em_scl : es_scl;
            end
            em_sda = 1'b1; es_sda = 1'b1; em_scl = 1'b1; es_scl = 1'b1;
            step(25);
        end
        scl_dir = 1'b0;

        // R10: disable request waits for idle
        em_sda = 1'b0; step(4);
        link_en = 1'b0; step(30);
        chk("R10 not cut", sda_s_pull, 1'b1);
        em_sda = 1'b1; step(40);
        em_sda = 1'b0; step(6);
        chk("R10 disabled data", sda_s_pull, 1'b0);
        em_scl = 1'b0; step(4);
        chk("R10 disabled clock", scl_s_pull, 1'b0);
        em_sda = 1'b1;

        // R10: enable request blocked by a busy clock line
        link_en = 1'b1; step(30);
        chk("R10 busy stays off", scl_s_pull, 1'b0);
        em_scl = 1'b1; step(30);
        em_scl = 1'b0; step(2);
        chk("R10 enabled after idle", scl_s_pull, 1'b1);
        em_scl = 1'b1; step(4);

        done = 1'b1;
        finish_run();
    end
endmodule